// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Register Slave

This block is the register-access front end of a small timekeeping peripheral on an 8-bit shared address/data bus. A host first places a register address on the shared lines and pulses an active-high address strobe. The block keeps the address value present when that strobe falls. The host then performs a read or a write with active-low read and write strobes, qualified by an active-low chip select. Each access reaches one byte of a 128-location register file. Locations 0x00 to 0x0D are the fourteen clock and control registers, and locations 0x0E to 0x7F are 114 bytes of general-purpose RAM.

All strobes and the bus lines enter the system clock domain through two-stage synchronizers. Edges are detected on the synchronized copies. Write data is the last bus value seen while the write strobe is low, and it is committed when the write strobe rises. The block asks for the bus only while both read strobe and chip select are low. The bus is modelled as separate input, output and output-enable ports, so the surrounding logic can build the tri-state pad.

A few register bits are fixed. The top bit of the seconds register and the top bit of control register A always read 0, and writes to them are discarded. Control registers C and D are read-only and read as zero, because no status source feeds them inside this block.

Top module: `mux_bus_regslave`

## Requirements
- R1: The register address is the bus value captured when the synchronized address strobe falls. The capture happens whatever the chip select level is, and the address holds until the next falling edge.
- R2: A write takes effect only if chip select is low for the whole write-strobe pulse, including the cycle the strobe rises. A write with chip select high, or with chip select released during the pulse, leaves every location unchanged.
- R3: The byte written is the last bus value sampled while the write strobe was low, even if the bus changed earlier in the pulse.
- R4: Output enable `ad_oe` is high only while both read strobe and chip select are low. It rises two clock edges after both go low and falls two clock edges after the read strobe rises.
- R5: While `ad_oe` is high, `ad_o` carries the byte stored at the latched address.
- R6: Bit 7 of location 0x00 (seconds) and bit 7 of location 0x0A (control A) are read-only, read 0, and ignore written values. The other seven bits of those locations are writable.
- R7: Locations 0x0C and 0x0D are fully read-only and always read 0x00.
- R8: Locations 0x01 to 0x09, 0x0B and 0x0E to 0x7F store all 8 written bits.
- R9: Addresses 0x80 to 0xFF are unmapped. Writes to them are ignored, and reads return 0x00.
- R10: After reset every location reads 0x00, the latched address is 0x00, and `ad_oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_i | input | 8 | Value currently on the shared address/data lines |
| ad_o | output | 8 | Read data to place on the shared lines |
| ad_oe | output | 1 | High when the block drives the shared lines |
| ale | input | 1 | Address strobe, active high; address taken on its falling edge |
| cs_n | input | 1 | Chip select, active low; gates data transfer only |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |

## Verification
Several internal faults show up at the ports. A wrong latched address appears as the wrong byte in the next read after the address strobe falls. A lost chip-select qualification appears as a changed byte after a write that should have been refused, visible on the following read. A broken read-only mask shows a 1 in a forced bit on the read-back right after the write. Output-enable timing is visible directly: a miscounted synchronizer moves the rise or fall of `ad_oe` away from the second clock edge after the strobe change, and the bench samples exactly at that edge.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned CLK_REGS  = 14;
  localparam int unsigned RAM_BYTES = 114;
  localparam int unsigned DEPTH     = CLK_REGS + RAM_BYTES;
  localparam int unsigned IDX_W     = $clog2(DEPTH);

  localparam int unsigned LOC_SECONDS = 0;
  localparam int unsigned LOC_CTRL_A  = 10;
  localparam int unsigned LOC_CTRL_C  = 12;
  localparam int unsigned LOC_CTRL_D  = 13;

  // Bits of a location that software may change.
  function automatic logic [DATA_W-1:0] writable_bits(input int unsigned loc);
    logic [DATA_W-1:0] m;
    m = '1;
    if (loc == LOC_SECONDS || loc == LOC_CTRL_A) m[DATA_W-1] = 1'b0;
    if (loc == LOC_CTRL_C || loc == LOC_CTRL_D) m = '0;
    if (loc >= DEPTH) m = '0;
    return m;
  endfunction

  function automatic logic is_mapped(input logic [ADDR_W-1:0] a);
    return (int'(a) < DEPTH);
  endfunction
endpackage

// File: rtl/mbs_sync.sv
module mbs_sync #(
  parameter int unsigned    WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic stage1_q, stage2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1_q <= RST_VAL[g];
        stage2_q <= RST_VAL[g];
      end else begin
        stage1_q <= d_i[g];
        stage2_q <= stage1_q;
      end
    end
    assign q_o[g] = stage2_q;
  end
endmodule

// File: rtl/mbs_bus_ctrl.sv
module mbs_bus_ctrl
  import mbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale_s,
  input  logic              cs_n_s,
  input  logic              rd_n_s,
  input  logic              wr_n_s,
  input  logic [DATA_W-1:0] ad_s,
  output logic [ADDR_W-1:0] addr_q,
  output logic              wr_commit,
  output logic [DATA_W-1:0] wdata_q,
  output logic              drive_en
);
  logic ale_prev_q, wr_prev_q, cs_held_q;
  logic ale_fall, wr_fall, wr_rise;

  assign ale_fall = ale_prev_q & ~ale_s;
  assign wr_fall  = wr_prev_q & ~wr_n_s;
  assign wr_rise  = ~wr_prev_q & wr_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_prev_q <= 1'b0;
      wr_prev_q  <= 1'b1;
      cs_held_q  <= 1'b0;
      addr_q     <= '0;
      wdata_q    <= '0;
    end else begin
      ale_prev_q <= ale_s;
      wr_prev_q  <= wr_n_s;
      if (ale_fall) addr_q <= ad_s;
      if (!wr_n_s) wdata_q <= ad_s;
      if (wr_fall) cs_held_q <= ~cs_n_s;
      else if (!wr_n_s && cs_n_s) cs_held_q <= 1'b0;
    end
  end

  assign wr_commit = wr_rise & cs_held_q & ~cs_n_s;
  assign drive_en  = ~rd_n_s & ~cs_n_s;

  AST_ADDR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !ale_fall |=> $stable(addr_q)); // R1
  AST_WRITE_HAD_CS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> $past(!cs_n_s)); // R2
endmodule

// File: rtl/mbs_regfile.sv
module mbs_regfile
  import mbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic              hit;

  assign hit = is_mapped(addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we && hit) begin
      for (int i = 0; i < DEPTH; i++)
        if (int'(addr) == i) mem_q[i] <= wdata & writable_bits(i);
    end
  end

  always_comb begin
    rdata = '0;
    if (hit) rdata = mem_q[addr[IDX_W-1:0]];
  end

  AST_CTRL_C_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(addr) == LOC_CTRL_C) |-> (rdata == '0)); // R7
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    addr[ADDR_W-1] |-> (rdata == '0)); // R9
endmodule

// File: rtl/mux_bus_regslave.sv
module mux_bus_regslave
  import mbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] ad_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe,
  input  logic              ale,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n
);
  localparam int unsigned SYNC_W = DATA_W + 4;
  localparam logic [SYNC_W-1:0] SYNC_RST = {1'b0, 1'b1, 1'b1, 1'b1, {DATA_W{1'b0}}};

  logic [SYNC_W-1:0] sync_q;
  logic              ale_s, cs_n_s, rd_n_s, wr_n_s;
  logic [DATA_W-1:0] ad_s;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_commit;
  logic [DATA_W-1:0] wdata_q;

  mbs_sync #(.WIDTH(SYNC_W), .RST_VAL(SYNC_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({ale, cs_n, rd_n, wr_n, ad_i}),
    .q_o   (sync_q)
  );

  assign {ale_s, cs_n_s, rd_n_s, wr_n_s, ad_s} = sync_q;

  mbs_bus_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ale_s     (ale_s),
    .cs_n_s    (cs_n_s),
    .rd_n_s    (rd_n_s),
    .wr_n_s    (wr_n_s),
    .ad_s      (ad_s),
    .addr_q    (addr_q),
    .wr_commit (wr_commit),
    .wdata_q   (wdata_q),
    .drive_en  (ad_oe)
  );

  mbs_regfile u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_commit),
    .addr  (addr_q),
    .wdata (wdata_q),
    .rdata (ad_o)
  );

  AST_OE_NEEDS_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> (!$past(rd_n, 2) && !$past(cs_n, 2))); // R4
  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n) |-> ##2 !ad_oe); // R4
endmodule

// File: tb/test_mux_bus_regslave.sv
module test_mux_bus_regslave;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ale = 1'b0, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic       host_en = 1'b0;
  logic [7:0] host_val = 8'h00;
  logic [7:0] ad_o;
  logic       ad_oe;
  logic [7:0] bus;
  int         checks = 0, failures = 0;
  bit         done = 0;

  // shared lines: host drives, else block drives, else pulled to 0
  assign bus = host_en ? host_val : (ad_oe ? ad_o : 8'h00);

  always #2 clk = ~clk;

  mux_bus_regslave i_mux_bus_regslave (
    .clk(clk), .rst_n(rst_n), .ad_i(bus), .ad_o(ad_o), .ad_oe(ad_oe),
    .ale(ale), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n)
  );

  // {addr, write data, expected read-back}
  localparam logic [23:0] VEC [10] = '{
    {8'h00, 8'hFF, 8'h7F},  // R6 seconds msb
    {8'h0A, 8'hFF, 8'h7F},  // R6 control A msb
    {8'h0B, 8'hA5, 8'hA5},  // R8
    {8'h05, 8'h81, 8'h81},  // R8
    {8'h0C, 8'hFF, 8'h00},  // R7
    {8'h0D, 8'h5A, 8'h00},  // R7
    {8'h0E, 8'h3C, 8'h3C},  // R8 first RAM byte
    {8'h7F, 8'hC3, 8'hC3},  // R8 last RAM byte
    {8'h80, 8'h55, 8'h00},  // R9
    {8'hFF, 8'hAA, 8'h00}   // R9
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic addr_phase(input logic [7:0] a, input logic sel_n);
    host_val = a; host_en = 1'b1; cs_n = sel_n; ale = 1'b1;
    idle(3);
    ale = 1'b0;
    idle(4);
    host_en = 1'b0; cs_n = 1'b1;
    idle(2);
  endtask

  task automatic write_phase(input logic [7:0] d, input logic sel_n);
    host_val = d; host_en = 1'b1; cs_n = sel_n; wr_n = 1'b0;
    idle(4);
    wr_n = 1'b1;
    idle(4);
    host_en = 1'b0; cs_n = 1'b1;
    idle(2);
  endtask

  task automatic read_phase(output logic [7:0] d);
    cs_n = 1'b0; rd_n = 1'b0;
    idle(4);
    d = bus;
    rd_n = 1'b1;
    idle(4);
    cs_n = 1'b1;
    idle(2);
  endtask

  task automatic wr_at(input logic [7:0] a, input logic [7:0] d);
    addr_phase(a, 1'b0);
    write_phase(d, 1'b0);
  endtask

  task automatic rd_at(input logic [7:0] a, output logic [7:0] d);
    addr_phase(a, 1'b0);
    read_phase(d);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] rd;
    idle(3);
    check("R10 oe in reset", {7'd0, ad_oe}, 8'h00);
    rst_n = 1'b1;
    idle(3);
    // R10: no address phase yet, so latched address is 0x00 holding 0
    read_phase(rd);
    check("R10 reset addr/data", rd, 8'h00);
    rd_at(8'h0E, rd);
    check("R10 RAM reset", rd, 8'h00);

    // table walk: R6 R7 R8 R9
    foreach (VEC[i]) begin
      wr_at(VEC[i][23:16], VEC[i][15:8]);
      rd_at(VEC[i][23:16], rd);
      check($sformatf("R5 vec%0d", i), rd, VEC[i][7:0]);
    end
    // R9: the unmapped write left mapped RAM intact
    rd_at(8'h7F, rd);
    check("R9 no alias into RAM", rd, 8'hC3);

    // R4: enable latency and release at two edges
    addr_phase(8'h0B, 1'b0);
    cs_n = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    check("R4 oe not yet after 1 edge", {7'd0, ad_oe}, 8'h00);
    @(negedge clk);
    check("R4 oe after 2 edges", {7'd0, ad_oe}, 8'h01);
    check("R5 data while oe", ad_o, 8'hA5);
    rd_n = 1'b1;
    @(negedge clk);
    check("R4 oe held 1 edge after rd high", {7'd0, ad_oe}, 8'h01);
    @(negedge clk);
    check("R4 oe released", {7'd0, ad_oe}, 8'h00);
    cs_n = 1'b1;
    idle(3);

    // R4: read strobe with chip select high never drives
    cs_n = 1'b1; rd_n = 1'b0;
    idle(4);
    check("R4 no drive without cs", {7'd0, ad_oe}, 8'h00);
    rd_n = 1'b1;
    idle(3);

    // R1: address strobe with chip select high still latches
    wr_at(8'h20, 8'h6E);
    addr_phase(8'h05, 1'b0);
    addr_phase(8'h20, 1'b1);
    read_phase(rd);
    check("R1 latch without cs", rd, 8'h6E);

    // R2: write with chip select high ignored
    write_phase(8'h11, 1'b1);
    read_phase(rd);
    check("R2 write without cs", rd, 8'h6E);

    // R2: chip select released mid-pulse ignored
    host_val = 8'h22; host_en = 1'b1; cs_n = 1'b0; wr_n = 1'b0;
    idle(3);
    cs_n = 1'b1;
    idle(3);
    wr_n = 1'b1;
    idle(4);
    host_en = 1'b0;
    idle(2);
    read_phase(rd);
    check("R2 cs dropped mid-write", rd, 8'h6E);

    // R3: last value on the bus during the pulse wins
    host_val = 8'h11; host_en = 1'b1; cs_n = 1'b0; wr_n = 1'b0;
    idle(3);
    host_val = 8'h99;
    idle(4);
    wr_n = 1'b1;
    idle(4);
    host_en = 1'b0; cs_n = 1'b1;
    idle(2);
    read_phase(rd);
    check("R3 late write data", rd, 8'h99);

    // R6: low bits of control A still writable
    wr_at(8'h0A, 8'h26);
    rd_at(8'h0A, rd);
    check("R6 ctrl A low bits", rd, 8'h26);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule